// File: doc/BRIEF.md
# Reorder Buffer with Flush

This block keeps speculative instructions in program order between issue and retirement. An issuing instruction claims the slot at the tail of a sixteen-slot ring and gets that slot's index as its tag. Results come back on a shared broadcast bus, in any order, and are held in the slot the bus tag names. The oldest slot retires when its result is present. A register-writing slot drives a register-file write, a store drives a memory write, and a branch that was not taken retires with no visible effect.

Branches are assumed not taken at issue. When the oldest slot is a branch whose resolved outcome was taken, the block raises a one-cycle flush and presents the branch target as the redirect PC. Every slot, every pending register mark, and any issue attempted in that cycle are dropped.

The block also keeps a table with one entry per architectural register. Each entry holds a pending mark and the tag of the youngest in-flight writer of that register. An issue stage reads two source registers from this table through two lookup ports. The lookup tells it whether to take the operand value from the register file or to wait for a tag on the bus.

Top module: `reorder_buf`

## Requirements
- R1: After reset the ring is empty, the next tag is 0, every register reads as ready on both lookup ports, and the register-write, memory-write and flush outputs are low.
- R2: An issue is accepted exactly when `issueValid` and `issueRsFree` are both high, the ring is not full and no flush is being signalled. Each accepted issue receives the current tail index as its tag, and the tail then advances by one, wrapping from 15 to 0.
- R3: With sixteen slots occupied no issue is accepted, even in a cycle where the head retires. An accepted issue and a retirement in the same cycle leave the occupancy unchanged.
- R4: A bus write carrying the tag of a free slot is discarded. A later issue that reuses that slot still waits for its own result.
- R5: Retirement is strictly in order. A slot whose result arrived early is held until every older slot has retired, and the head retires in the cycle after its result is recorded.
- R6: When the head is kind 0 (register write) with its result present, `regWrEn` is high for one cycle, with the destination on `regWrAddr` and the result on `regWrData`.
- R7: When the head is kind 1 (store) with its result present, `memWrEn` is high for one cycle, with the bus-supplied address on `memWrAddr` and the result on `memWrData`.
- R8: A kind 2 (branch) head that resolved not taken, or a kind 3 head, retires with no register write, no memory write and no flush.
- R9: A kind 2 head that resolved taken raises `flush` for one cycle, with the bus result on `redirectPc`. In the next cycle the ring is empty, the next tag is 0, every register reads as ready, and no younger slot ever retires.
- R10: An accepted kind 0 issue marks its destination pending with the new tag, visible on the lookup ports from the next cycle. Kinds 1 to 3 leave the table untouched.
- R11: A register becomes ready on retirement only if its recorded tag equals the retiring slot's tag. Otherwise it stays pending on the younger writer.
- R12: When a kind 0 issue and a kind 0 retirement of the same register occur in one cycle, the new issue's pending mark and tag win.
- R13: An issue attempted during a flush cycle is not accepted and leaves no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Issue stage requests a slot |
| issueRsFree | input | 1 | A reservation station is free for this issue |
| issueKind | input | 2 | 0 register write, 1 store, 2 branch, 3 no effect |
| issueDest | input | 5 | Destination register of the issuing instruction |
| issueAccept | output | 1 | The issue is taken this cycle |
| issueTag | output | 4 | Tag (tail index) handed to the issuing instruction |
| srcRegA | input | 5 | First register looked up in the status table |
| srcRegB | input | 5 | Second register looked up in the status table |
| srcReadyA | output | 1 | First register holds its committed value |
| srcReadyB | output | 1 | Second register holds its committed value |
| srcTagA | output | 4 | Pending writer tag of the first register |
| srcTagB | output | 4 | Pending writer tag of the second register |
| cdbValid | input | 1 | Broadcast bus carries a result |
| cdbTag | input | 4 | Slot the bus result belongs to |
| cdbResult | input | 32 | Result value, or branch target for branches |
| cdbAddr | input | 32 | Store address for stores |
| cdbTaken | input | 1 | Branch resolved taken |
| regWrEn | output | 1 | Register file write strobe |
| regWrAddr | output | 5 | Register file write index |
| regWrData | output | 32 | Register file write value |
| memWrEn | output | 1 | Memory store strobe |
| memWrAddr | output | 32 | Memory store address |
| memWrData | output | 32 | Memory store value |
| flush | output | 1 | Mispredicted branch at head, discard everything |
| redirectPc | output | 32 | Fetch redirect target during flush |

## Verification
The bench returns results out of order. A design that retired whichever slot finished first would emit the younger write before the older one. It also fills the ring across the wrap point and tries to issue on the cycle the full ring retires, and then on a cycle that both retires and allocates. An occupancy count that mishandled either case would accept a seventeenth issue or refuse a legal one. A register is rewritten while an older writer is still in flight, and again in the very cycle that older writer retires. A table that cleared pending marks without comparing tags would show the register as ready too early. A taken branch is resolved behind a younger store and a younger register write whose results have already arrived. Any retirement after the flush, a stale pending mark, or a non-zero next tag exposes an incomplete flush. A bus write aimed at a free slot must not make the next occupant of that slot look finished.

// File: rtl/reorder_buf_pkg.sv
package reorder_buf_pkg;
  parameter int ROB_ENTRIES = 16;
  parameter int REG_COUNT   = 32;
  parameter int DATA_W      = 32;
  parameter int SRC_PORTS   = 2;

  localparam int TAG_W = $clog2(ROB_ENTRIES);
  localparam int REG_W = $clog2(REG_COUNT);
  localparam int CNT_W = TAG_W + 1;

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [REG_W-1:0]  regIdx_t;
  typedef logic [DATA_W-1:0] data_t;

  // Kind codes seen at the issue port
  typedef enum logic [1:0] {
    OP_REGWR  = 2'd0,
    OP_STORE  = 2'd1,
    OP_BRANCH = 2'd2,
    OP_NONE   = 2'd3
  } opKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic alloc;
    logic retire;
    logic flush;
    tag_t headIdx;
    tag_t tailIdx;
  } robStrobe_t;

  typedef struct packed {
    logic    busy;
    logic    done;
    opKind_e kind;
    regIdx_t dest;
    logic    taken;
    data_t   result;
    data_t   addr;
  } robEntry_t;
endpackage

// File: rtl/reorder_buf_ctrl.sv
module reorder_buf_ctrl
  import reorder_buf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       issueValid,
  input  logic       issueRsFree,
  input  logic       headBusy,
  input  logic       headDone,
  input  opKind_e    headKind,
  input  logic       headTaken,
  output robStrobe_t strobe,
  output logic       issueAccept
);
  logic [CNT_W-1:0] occupancy;
  tag_t headPtr;
  tag_t tailPtr;
  logic headReady, flushNow, retireNow, allocNow, robFull;

  function automatic tag_t bump(input tag_t p);
    if (p == tag_t'(ROB_ENTRIES - 1)) return '0;
    return p + tag_t'(1);
  endfunction

  always_comb begin
    headReady = headBusy & headDone;
    flushNow  = headReady & (headKind == OP_BRANCH) & headTaken;
    retireNow = headReady & ~flushNow;
    robFull   = (occupancy == CNT_W'(ROB_ENTRIES));
    allocNow  = issueValid & issueRsFree & ~robFull & ~flushNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      occupancy <= '0;
      headPtr   <= '0;
      tailPtr   <= '0;
    end else if (flushNow) begin
      occupancy <= '0;
      headPtr   <= '0;
      tailPtr   <= '0;
    end else begin
      if (retireNow) headPtr <= bump(headPtr);
      if (allocNow)  tailPtr <= bump(tailPtr);
      case ({allocNow, retireNow})
        2'b10:   occupancy <= occupancy + CNT_W'(1);
        2'b01:   occupancy <= occupancy - CNT_W'(1);
        default: occupancy <= occupancy;
      endcase
    end
  end

  assign strobe.alloc   = allocNow;
  assign strobe.retire  = retireNow;
  assign strobe.flush   = flushNow;
  assign strobe.headIdx = headPtr;
  assign strobe.tailIdx = tailPtr;
  assign issueAccept    = allocNow;
endmodule

// File: rtl/reorder_buf_data.sv
module reorder_buf_data
  import reorder_buf_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  robStrobe_t                        strobe,
  input  opKind_e                           issueKind,
  input  regIdx_t                           issueDest,
  input  logic                              cdbValid,
  input  tag_t                              cdbTag,
  input  data_t                             cdbResult,
  input  data_t                             cdbAddr,
  input  logic                              cdbTaken,
  input  logic [SRC_PORTS-1:0][REG_W-1:0]   srcReg,
  output logic [SRC_PORTS-1:0]              srcReady,
  output logic [SRC_PORTS-1:0][TAG_W-1:0]   srcTag,
  output logic                              headBusy,
  output logic                              headDone,
  output opKind_e                           headKind,
  output logic                              headTaken,
  output logic                              regWrEn,
  output regIdx_t                           regWrAddr,
  output data_t                             regWrData,
  output logic                              memWrEn,
  output data_t                             memWrAddr,
  output data_t                             memWrData,
  output data_t                             redirectPc
);
  robEntry_t slots [ROB_ENTRIES];
  logic [REG_COUNT-1:0] regPending;
  tag_t regOwner [REG_COUNT];
  robEntry_t headEntry;

  assign headEntry = slots[strobe.headIdx];

  // Slot array
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ROB_ENTRIES; i++) slots[i] <= '0;
    end else if (strobe.flush) begin
      for (int i = 0; i < ROB_ENTRIES; i++) begin
        slots[i].busy <= 1'b0;
        slots[i].done <= 1'b0;
      end
    end else begin
      if (strobe.retire) begin
        slots[strobe.headIdx].busy <= 1'b0;
        slots[strobe.headIdx].done <= 1'b0;
      end
      if (strobe.alloc) begin
        slots[strobe.tailIdx].busy  <= 1'b1;
        slots[strobe.tailIdx].done  <= 1'b0;
        slots[strobe.tailIdx].kind  <= issueKind;
        slots[strobe.tailIdx].dest  <= issueDest;
        slots[strobe.tailIdx].taken <= 1'b0;
      end
      // A result is only taken by an occupied slot still waiting for it
      if (cdbValid && slots[cdbTag].busy && !slots[cdbTag].done) begin
        slots[cdbTag].done   <= 1'b1;
        slots[cdbTag].result <= cdbResult;
        slots[cdbTag].addr   <= cdbAddr;
        slots[cdbTag].taken  <= cdbTaken;
      end
    end
  end

  // Register result status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regPending <= '0;
      for (int r = 0; r < REG_COUNT; r++) regOwner[r] <= '0;
    end else if (strobe.flush) begin
      regPending <= '0;
    end else begin
      if (strobe.retire && headEntry.kind == OP_REGWR &&
          regPending[headEntry.dest] && regOwner[headEntry.dest] == strobe.headIdx)
        regPending[headEntry.dest] <= 1'b0;
      // A new writer issued in the same cycle overrides the release above
      if (strobe.alloc && issueKind == OP_REGWR) begin
        regPending[issueDest] <= 1'b1;
        regOwner[issueDest]   <= strobe.tailIdx;
      end
    end
  end

  for (genvar p = 0; p < SRC_PORTS; p++) begin : gLookup
    assign srcReady[p] = ~regPending[srcReg[p]];
    assign srcTag[p]   = regOwner[srcReg[p]];
  end

  assign headBusy   = headEntry.busy;
  assign headDone   = headEntry.done;
  assign headKind   = headEntry.kind;
  assign headTaken  = headEntry.taken;
  assign regWrEn    = strobe.retire & (headEntry.kind == OP_REGWR);
  assign regWrAddr  = headEntry.dest;
  assign regWrData  = headEntry.result;
  assign memWrEn    = strobe.retire & (headEntry.kind == OP_STORE);
  assign memWrAddr  = headEntry.addr;
  assign memWrData  = headEntry.result;
  assign redirectPc = headEntry.result;
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import reorder_buf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic              issueRsFree,
  input  logic [1:0]        issueKind,
  input  logic [REG_W-1:0]  issueDest,
  output logic              issueAccept,
  output logic [TAG_W-1:0]  issueTag,
  input  logic [REG_W-1:0]  srcRegA,
  input  logic [REG_W-1:0]  srcRegB,
  output logic              srcReadyA,
  output logic              srcReadyB,
  output logic [TAG_W-1:0]  srcTagA,
  output logic [TAG_W-1:0]  srcTagB,
  input  logic              cdbValid,
  input  logic [TAG_W-1:0]  cdbTag,
  input  logic [DATA_W-1:0] cdbResult,
  input  logic [DATA_W-1:0] cdbAddr,
  input  logic              cdbTaken,
  output logic              regWrEn,
  output logic [REG_W-1:0]  regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              memWrEn,
  output logic [DATA_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              flush,
  output logic [DATA_W-1:0] redirectPc
);
  robStrobe_t strobe;
  logic headBusy, headDone, headTaken;
  opKind_e headKind;
  logic [SRC_PORTS-1:0][REG_W-1:0] srcRegVec;
  logic [SRC_PORTS-1:0]            srcReadyVec;
  logic [SRC_PORTS-1:0][TAG_W-1:0] srcTagVec;

  assign srcRegVec = {srcRegB, srcRegA};
  assign srcReadyA = srcReadyVec[0];
  assign srcReadyB = srcReadyVec[1];
  assign srcTagA   = srcTagVec[0];
  assign srcTagB   = srcTagVec[1];
  assign flush     = strobe.flush;
  assign issueTag  = strobe.tailIdx;

  reorder_buf_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueRsFree(issueRsFree),
    .headBusy(headBusy), .headDone(headDone),
    .headKind(headKind), .headTaken(headTaken),
    .strobe(strobe), .issueAccept(issueAccept)
  );

  reorder_buf_data uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .issueKind(opKind_e'(issueKind)), .issueDest(issueDest),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbResult(cdbResult),
    .cdbAddr(cdbAddr), .cdbTaken(cdbTaken),
    .srcReg(srcRegVec), .srcReady(srcReadyVec), .srcTag(srcTagVec),
    .headBusy(headBusy), .headDone(headDone),
    .headKind(headKind), .headTaken(headTaken),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .redirectPc(redirectPc)
  );
endmodule

// File: rtl/reorder_buf_chk.sv
module reorder_buf_chk
  import reorder_buf_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             issueValid,
  input logic             issueRsFree,
  input logic             issueAccept,
  input logic [TAG_W-1:0] issueTag,
  input logic             flush,
  input logic             regWrEn,
  input logic             memWrEn
);
  assert_accept_needs_request_R2: assert property (@(posedge clk) disable iff (!rstN)
    issueAccept |-> (issueValid && issueRsFree));

  assert_no_issue_in_flush_R13: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !issueAccept);

  assert_tail_steps_R2: assert property (@(posedge clk) disable iff (!rstN)
    issueAccept |=> (issueTag == TAG_W'($past(issueTag) + 1'b1)));

  assert_tail_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!issueAccept && !flush) |=> $stable(issueTag));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (issueTag == '0) && !flush);

  assert_single_commit_action_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({regWrEn, memWrEn, flush}));
endmodule

bind reorder_buf reorder_buf_chk uChk (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueRsFree(issueRsFree),
  .issueAccept(issueAccept), .issueTag(issueTag), .flush(flush),
  .regWrEn(regWrEn), .memWrEn(memWrEn)
);

// File: tb/reorder_buf_test.sv
module reorder_buf_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic issueValid = 1'b0, issueRsFree = 1'b1;
  logic [1:0] issueKind = '0;
  logic [4:0] issueDest = '0;
  logic issueAccept;
  logic [3:0] issueTag;
  logic [4:0] srcRegA = 5'd7, srcRegB = 5'd31;
  logic srcReadyA, srcReadyB;
  logic [3:0] srcTagA, srcTagB;
  logic cdbValid = 1'b0, cdbTaken = 1'b0;
  logic [3:0] cdbTag = '0;
  logic [31:0] cdbResult = '0, cdbAddr = '0;
  logic regWrEn, memWrEn, flush;
  logic [4:0] regWrAddr;
  logic [31:0] regWrData, memWrAddr, memWrData, redirectPc;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  typedef struct {
    int          what;   // 0 register write, 1 store, 2 flush
    logic [31:0] addr;
    logic [31:0] data;
  } expEv_t;
  expEv_t expQ[$];

  always #5 clk = ~clk;

  reorder_buf uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueRsFree(issueRsFree),
    .issueKind(issueKind), .issueDest(issueDest), .issueAccept(issueAccept),
    .issueTag(issueTag), .srcRegA(srcRegA), .srcRegB(srcRegB),
    .srcReadyA(srcReadyA), .srcReadyB(srcReadyB), .srcTagA(srcTagA), .srcTagB(srcTagB),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbResult(cdbResult), .cdbAddr(cdbAddr),
    .cdbTaken(cdbTaken), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .flush(flush), .redirectPc(redirectPc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
    issueValid = 1'b0; issueRsFree = 1'b1;
    cdbValid = 1'b0; cdbTaken = 1'b0;
  endtask

  task automatic doIssue(input logic [1:0] k, input logic [4:0] d,
                         input logic expAcc, input logic [3:0] expTag, input string req);
    issueValid = 1'b1; issueKind = k; issueDest = d;
    #3;
    chk({req, " accept"}, 32'(issueAccept), 32'(expAcc));
    if (expAcc) chk({req, " tag"}, 32'(issueTag), 32'(expTag));
    tick();
  endtask

  task automatic doCdb(input logic [3:0] t, input logic [31:0] res,
                       input logic [31:0] a, input logic tk);
    cdbValid = 1'b1; cdbTag = t; cdbResult = res; cdbAddr = a; cdbTaken = tk;
    tick();
  endtask

  task automatic pushEv(input int w, input logic [31:0] a, input logic [31:0] d);
    expEv_t e;
    e.what = w; e.addr = a; e.data = d;
    expQ.push_back(e);
  endtask

  // Scoreboard monitor: every commit action is matched in program order
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && (regWrEn || memWrEn || flush)) begin
        int actWhat;
        logic [31:0] actA, actD;
        actWhat = flush ? 2 : (memWrEn ? 1 : 0);
        actA = flush ? 32'd0 : (memWrEn ? memWrAddr : 32'(regWrAddr));
        actD = flush ? redirectPc : (memWrEn ? memWrData : regWrData);
        vectors++;
        if (expQ.size() == 0) begin
          miscompares++;
          $display("FAIL R5/R8/R9: actual action %0d a=%h d=%h expected none", actWhat, actA, actD);
        end else begin
          expEv_t e;
          e = expQ.pop_front();
          if (actWhat != e.what || actA !== e.addr || actD !== e.data) begin
            miscompares++;
            $display("FAIL R5/R6/R7/R9: actual action %0d a=%h d=%h expected action %0d a=%h d=%h",
                     actWhat, actA, actD, e.what, e.addr, e.data);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #3;
    // R1 reset state
    chk("R1 tag", 32'(issueTag), 32'd0);
    chk("R1 readyA", 32'(srcReadyA), 32'd1);
    chk("R1 readyB", 32'(srcReadyB), 32'd1);
    chk("R1 outputs", 32'({regWrEn, memWrEn, flush, issueAccept}), 32'd0);
    tick();

    // Out-of-order completion, register table, tag overwrite
    srcRegA = 5'd3; srcRegB = 5'd9;
    pushEv(0, 32'd3, 32'h111);
    doIssue(2'd0, 5'd3, 1'b1, 4'd0, "R2 first");
    #3;
    chk("R10 pending", 32'(srcReadyA), 32'd0);
    chk("R10 tag", 32'(srcTagA), 32'd0);
    pushEv(1, 32'h40, 32'h222);
    doIssue(2'd1, 5'd9, 1'b1, 4'd1, "R2 store");
    #3;
    chk("R10 store leaves table", 32'(srcReadyB), 32'd1);
    pushEv(0, 32'd3, 32'h333);
    doIssue(2'd0, 5'd3, 1'b1, 4'd2, "R2 second writer");
    #3;
    chk("R11 newer tag", 32'(srcTagA), 32'd2);
    issueRsFree = 1'b0;
    doIssue(2'd0, 5'd4, 1'b0, 4'd0, "R2 no station");
    doCdb(4'd2, 32'h333, 32'd0, 1'b0);
    tick(); #3;
    chk("R5 younger held", 32'(regWrEn), 32'd0);
    doCdb(4'd0, 32'h111, 32'd0, 1'b0);
    tick(); #3;
    chk("R11 still pending", 32'(srcReadyA), 32'd0);
    chk("R11 owner kept", 32'(srcTagA), 32'd2);
    doCdb(4'd1, 32'h222, 32'h40, 1'b0);
    tick(); tick(); #3;
    chk("R11 released", 32'(srcReadyA), 32'd1);

    // Fill across the wrap point, full handling
    for (int i = 0; i < 16; i++)
      doIssue(2'd2, 5'd0, 1'b1, 4'((3 + i) % 16), "R2 wrap");
    doIssue(2'd2, 5'd0, 1'b0, 4'd0, "R3 full");
    doCdb(4'd3, 32'd0, 32'd0, 1'b0);
    doIssue(2'd2, 5'd0, 1'b0, 4'd0, "R3 full while retiring");
    doCdb(4'd4, 32'd0, 32'd0, 1'b0);
    doIssue(2'd2, 5'd0, 1'b1, 4'd3, "R3 alloc with retire");
    doIssue(2'd2, 5'd0, 1'b1, 4'd4, "R3 refill");
    doIssue(2'd2, 5'd0, 1'b0, 4'd0, "R3 count held");
    // R8: not-taken branches drain silently
    for (int i = 0; i < 16; i++)
      doCdb(4'((5 + i) % 16), 32'(i), 32'd0, 1'b0);
    tick(); tick(); tick(); #3;
    chk("R8 drained tail", 32'(issueTag), 32'd5);

    // Taken branch behind completed younger work
    srcRegA = 5'd10; srcRegB = 5'd11;
    pushEv(0, 32'd10, 32'h555);
    doIssue(2'd0, 5'd10, 1'b1, 4'd5, "R2 pre-branch");
    pushEv(2, 32'd0, 32'h1234);
    doIssue(2'd2, 5'd0, 1'b1, 4'd6, "R2 branch");
    doIssue(2'd0, 5'd11, 1'b1, 4'd7, "R2 shadow reg");
    doIssue(2'd1, 5'd12, 1'b1, 4'd8, "R2 shadow store");
    doCdb(4'd7, 32'h777, 32'd0, 1'b0);
    doCdb(4'd8, 32'h888, 32'h80, 1'b0);
    doCdb(4'd5, 32'h555, 32'd0, 1'b0);
    doCdb(4'd6, 32'h1234, 32'd0, 1'b1);
    issueValid = 1'b1; issueKind = 2'd0; issueDest = 5'd13;
    #3;
    chk("R9 flush", 32'(flush), 32'd1);
    chk("R9 redirect", redirectPc, 32'h1234);
    chk("R13 issue dropped", 32'(issueAccept), 32'd0);
    tick(); #3;
    chk("R9 tag reset", 32'(issueTag), 32'd0);
    chk("R9 table cleared A", 32'(srcReadyA), 32'd1);
    chk("R9 table cleared B", 32'(srcReadyB), 32'd1);
    chk("R9 single cycle", 32'(flush), 32'd0);
    tick(); tick(); tick();

    // Same-cycle issue and retirement to one register
    srcRegA = 5'd20;
    pushEv(0, 32'd20, 32'hAA);
    doIssue(2'd0, 5'd20, 1'b1, 4'd0, "R12 first");
    doCdb(4'd0, 32'hAA, 32'd0, 1'b0);
    pushEv(0, 32'd20, 32'hBB);
    doIssue(2'd0, 5'd20, 1'b1, 4'd1, "R12 overlap");
    #3;
    chk("R12 pending wins", 32'(srcReadyA), 32'd0);
    chk("R12 tag", 32'(srcTagA), 32'd1);
    doCdb(4'd1, 32'hBB, 32'd0, 1'b0);
    tick(); #3;
    chk("R11 ready after own commit", 32'(srcReadyA), 32'd1);

    // Bus write to a free slot
    doCdb(4'd2, 32'hDEAD, 32'd0, 1'b0);
    srcRegA = 5'd5;
    doIssue(2'd0, 5'd5, 1'b1, 4'd2, "R4 reuse");
    tick(); tick(); #3;
    chk("R4 stale write ignored", 32'(regWrEn), 32'd0);
    chk("R4 still pending", 32'(srcReadyA), 32'd0);
    pushEv(0, 32'd5, 32'h77);
    doCdb(4'd2, 32'h77, 32'd0, 1'b0);
    tick(); tick(); #3;

    chk("R5 all commits seen", 32'(expQ.size()), 32'd0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule